// File: doc/BRIEF.md
# Machine Timer with Gated Compare Interrupt

This block is the machine-level timer for a 32-bit core. It keeps a free-running 64-bit count and a 64-bit compare value. Software reaches both over a small 32-bit register bus, one half at a time. When the count has reached the compare value, the block raises a level timer request. It holds that request until software moves the compare value above the count.

A small gating stage sits after the request. It combines the registered request with a per-source timer enable and a global interrupt enable, and produces the signal that tells the core to take the interrupt. Trap entry itself lies outside the block.

The request side of the bus uses valid/ready. `bus_ready` is always high, so a request is accepted in the cycle in which `bus_valid` is high, and no back-pressure is ever applied. A read returns its data one cycle later, marked by `rsp_valid`. The response has no ready input: the core must take the data in the cycle it appears.

Top module: `mtimer_core`

## Requirements
- R1: The count rises by exactly one on each clock edge at which `tick_en` is high and no write to the count is accepted. With `tick_en` low and no write to the count, it holds its value.
- R2: After reset the count is 0, the compare value is all ones, `irq_req` is 0 and `rsp_valid` is 0.
- R3: `bus_addr` is a word index. 0 selects the count low half, 1 the count high half, 2 the compare low half and 3 the compare high half. A write changes only the selected 32-bit half.
- R4: `bus_ready` is always 1. An accepted read gives `rsp_valid` = 1 and its data on the following cycle. `rsp_valid` is 0 after a write or an idle cycle.
- R5: A read of index 0 returns the low half of the count and latches the current high half into a shadow. A read of index 1 returns that shadow, so the two reads together give one consistent 64-bit value even if a carry happens between them.
- R6: A write to either half of the count, accepted in a cycle where `tick_en` is high, loads the written value without also incrementing in that cycle.
- R7: `irq_req` equals the unsigned 64-bit result of count >= compare, registered one cycle later. It is a level: it stays 1 while the condition holds and clears only when the condition no longer holds.
- R8: `take_irq` is 1 exactly when `irq_req`, `mtie_en` and `glb_ie` are all 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count increment enable for this cycle |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Request accepted (always 1) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index of the register half |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| mtie_en | input | 1 | Timer interrupt source enable |
| glb_ie | input | 1 | Global interrupt enable |
| irq_req | output | 1 | Registered level timer request (pending) |
| take_irq | output | 1 | Gated request to take the interrupt |

## Verification
The hardest case to reach from the ports is a carry from the low half into the high half of the count that falls between the two halves of a 64-bit read. The bench loads the count a few steps below the 32-bit boundary, turns on the tick, and reads the low half. It then waits long enough for the carry to happen before reading the high half, and expects the pre-carry shadow value, not the live one. The compare boundaries are reached by stepping the count one tick at a time onto the compare value, and by putting the deciding difference only in the high compare half.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_CNT_LO = 2'd0,
    SEL_CNT_HI = 2'd1,
    SEL_CMP_LO = 2'd2,
    SEL_CMP_HI = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_split_reg.sv
// 64-bit register written as two halves; optionally counts up.
module tmr_split_reg #(
  parameter int unsigned HALF_W = 32,
  parameter bit          COUNT  = 1'b0,
  parameter logic [2*HALF_W-1:0] RST_VAL = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [HALF_W-1:0]   wdata,
  output logic [2*HALF_W-1:0] value
);
  localparam int unsigned FULL_W = 2 * HALF_W;

  logic [1:0]          wr_half;
  logic [FULL_W-1:0]   base;
  logic [FULL_W-1:0]   nxt;

  assign wr_half = {wr_hi, wr_lo};

  // writes win over the increment
  always_comb begin
    if (COUNT && step && (wr_half == 2'b00)) base = value + FULL_W'(1);
    else                                     base = value;
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_comb begin
      if (wr_half[h]) nxt[h*HALF_W +: HALF_W] = wdata;
      else            nxt[h*HALF_W +: HALF_W] = base[h*HALF_W +: HALF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) value <= RST_VAL;
    else        value <= nxt;
  end
endmodule

// File: rtl/tmr_irq_gate.sv
// Registered reach flag plus enable gating.
module tmr_irq_gate #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             src_en,
  input  logic             glb_en,
  output logic             pending,
  output logic             take
);
  logic reached;

  assign reached = (cnt >= cmp);

  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= reached;
  end

  assign take = pending & src_en & glb_en;
endmodule

// File: rtl/mtimer_core.sv
module mtimer_core #(
  parameter int unsigned BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             bus_valid,
  output logic             bus_ready,
  input  logic             bus_write,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic             rsp_valid,
  output logic [BUS_W-1:0] rsp_rdata,
  input  logic             mtie_en,
  input  logic             glb_ie,
  output logic             irq_req,
  output logic             take_irq
);
  import tmr_pkg::*;

  localparam int unsigned CNT_W = 2 * BUS_W;

  reg_sel_e          sel;
  logic              acc_wr, acc_rd;
  logic [CNT_W-1:0]  mtime_q;
  logic [CNT_W-1:0]  mtcmp_q;
  logic [BUS_W-1:0]  shadow_q;
  logic [BUS_W-1:0]  rd_mux;

  assign bus_ready = 1'b1;
  assign sel       = reg_sel_e'(bus_addr);
  assign acc_wr    = bus_valid &&  bus_write;
  assign acc_rd    = bus_valid && !bus_write;

  tmr_split_reg #(
    .HALF_W (BUS_W),
    .COUNT  (1'b1),
    .RST_VAL({CNT_W{1'b0}})
  ) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (tick_en),
    .wr_lo (acc_wr && sel == SEL_CNT_LO),
    .wr_hi (acc_wr && sel == SEL_CNT_HI),
    .wdata (bus_wdata),
    .value (mtime_q)
  );

  tmr_split_reg #(
    .HALF_W (BUS_W),
    .COUNT  (1'b0),
    .RST_VAL({CNT_W{1'b1}})
  ) u_compare (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (1'b0),
    .wr_lo (acc_wr && sel == SEL_CMP_LO),
    .wr_hi (acc_wr && sel == SEL_CMP_HI),
    .wdata (bus_wdata),
    .value (mtcmp_q)
  );

  tmr_irq_gate #(.CNT_W(CNT_W)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (mtime_q),
    .cmp     (mtcmp_q),
    .src_en  (mtie_en),
    .glb_en  (glb_ie),
    .pending (irq_req),
    .take    (take_irq)
  );

  always_comb begin
    unique case (sel)
      SEL_CNT_LO: rd_mux = mtime_q[BUS_W-1:0];
      SEL_CNT_HI: rd_mux = shadow_q;
      SEL_CMP_LO: rd_mux = mtcmp_q[BUS_W-1:0];
      SEL_CMP_HI: rd_mux = mtcmp_q[CNT_W-1:BUS_W];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      shadow_q  <= '0;
    end else begin
      rsp_valid <= acc_rd;
      if (acc_rd) rsp_rdata <= rd_mux;
      if (acc_rd && sel == SEL_CNT_LO) shadow_q <= mtime_q[CNT_W-1:BUS_W];
    end
  end
endmodule

// File: rtl/mtimer_core_chk.sv
module mtimer_core_chk #(
  parameter int unsigned BUS_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_en,
  input logic               bus_valid,
  input logic               bus_write,
  input logic [1:0]         bus_addr,
  input logic [BUS_W-1:0]   bus_wdata,
  input logic               rsp_valid,
  input logic               mtie_en,
  input logic               glb_ie,
  input logic               irq_req,
  input logic               take_irq,
  input logic [2*BUS_W-1:0] mtime,
  input logic [2*BUS_W-1:0] mtcmp
);
  logic cnt_wr, cnt_lo_wr;
  assign cnt_wr    = bus_valid && bus_write && (bus_addr[1] == 1'b0);
  assign cnt_lo_wr = bus_valid && bus_write && (bus_addr == 2'd0);

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cnt_wr) |=> $stable(mtime));

  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !cnt_wr) |=> (mtime == $past(mtime) + 1'b1));

  a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_lo_wr |=> (mtime[BUS_W-1:0] == $past(bus_wdata)));

  a_r4_read_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rsp_valid);

  a_r4_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !rsp_valid);

  a_r7_reach: assert property (@(posedge clk) disable iff (!rst_n)
    (mtime >= mtcmp) |=> irq_req);

  a_r7_below: assert property (@(posedge clk) disable iff (!rst_n)
    (mtime < mtcmp) |=> !irq_req);

  a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (irq_req && mtie_en && glb_ie));
endmodule

bind mtimer_core mtimer_core_chk #(.BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .rsp_valid (rsp_valid),
  .mtie_en   (mtie_en),
  .glb_ie    (glb_ie),
  .irq_req   (irq_req),
  .take_irq  (take_irq),
  .mtime     (mtime_q),
  .mtcmp     (mtcmp_q)
);

// File: tb/mtimer_core_bench.sv
module mtimer_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_write = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mtie_en = 1'b0;
  logic        glb_ie = 1'b0;
  logic        irq_req;
  logic        take_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] rd_val;

  always #10 clk = ~clk;

  mtimer_core u_mtimer_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mtie_en(mtie_en), .glb_ie(glb_ie),
    .irq_req(irq_req), .take_irq(take_irq)
  );

  // {write, index, wdata, expected read data}
  localparam int NV = 12;
  localparam logic [66:0] TBL [0:NV-1] = '{
    {1'b1, 2'd0, 32'h0000_0010, 32'h0},
    {1'b1, 2'd1, 32'h0000_0002, 32'h0},
    {1'b0, 2'd0, 32'h0,         32'h0000_0010},
    {1'b0, 2'd1, 32'h0,         32'h0000_0002},
    {1'b0, 2'd2, 32'h0,         32'hFFFF_FFFF},
    {1'b0, 2'd3, 32'h0,         32'hFFFF_FFFF},
    {1'b1, 2'd2, 32'h0000_0055, 32'h0},
    {1'b0, 2'd2, 32'h0,         32'h0000_0055},
    {1'b0, 2'd3, 32'h0,         32'hFFFF_FFFF},
    {1'b1, 2'd3, 32'h0000_0007, 32'h0},
    {1'b0, 2'd3, 32'h0,         32'h0000_0007},
    {1'b0, 2'd2, 32'h0,         32'h0000_0055}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one accepted request; returns at the negedge after the accepting edge
  task automatic op(input logic wr, input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = idx; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    rd_val = rsp_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: reset state
    check("R2 irq", {63'b0, irq_req}, 64'd0);
    check("R2 rsp_valid", {63'b0, rsp_valid}, 64'd0);
    check("R4 ready", {63'b0, bus_ready}, 64'd1);
    op(1'b0, 2'd0, 0);
    check("R2 count lo", {32'b0, rd_val}, 64'd0);
    op(1'b0, 2'd2, 0);
    check("R2 compare lo", {32'b0, rd_val}, 64'hFFFF_FFFF);

    // R3/R4: register map table, tick off
    for (int i = 0; i < NV; i++) begin
      op(TBL[i][66], TBL[i][65:64], TBL[i][63:32]);
      if (TBL[i][66]) check("R4 no rsp on write", {63'b0, rsp_valid}, 64'd0);
      else begin
        check("R4 rsp on read", {63'b0, rsp_valid}, 64'd1);
        check("R3 read data", {32'b0, rd_val}, {32'b0, TBL[i][31:0]});
      end
    end
    settle();
    check("R4 idle no rsp", {63'b0, rsp_valid}, 64'd0);

    // R1: counting
    op(1'b1, 2'd0, 0); op(1'b1, 2'd1, 0);
    @(negedge clk); tick_en = 1'b1;
    repeat (37) @(negedge clk);
    tick_en = 1'b0;
    op(1'b0, 2'd0, 0);
    check("R1 count 37 ticks", {32'b0, rd_val}, 64'd37);
    repeat (5) @(negedge clk);
    op(1'b0, 2'd0, 0);
    check("R1 hold without tick", {32'b0, rd_val}, 64'd37);

    // R6: write beats increment
    @(negedge clk);
    tick_en = 1'b1;
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 2'd0; bus_wdata = 32'h1000;
    @(negedge clk);
    tick_en = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    op(1'b0, 2'd0, 0);
    check("R6 write wins over tick", {32'b0, rd_val}, 64'h1000);
    op(1'b0, 2'd1, 0);
    check("R3 high half kept", {32'b0, rd_val}, 64'd0);

    // R5: carry between the two halves of a read
    op(1'b1, 2'd0, 32'hFFFF_FFF0); op(1'b1, 2'd1, 32'd5);
    @(negedge clk); tick_en = 1'b1;
    op(1'b0, 2'd0, 0);
    check("R5 low near boundary", {63'b0, (rd_val >= 32'hFFFF_FFF0) && (rd_val < 32'hFFFF_FFFC)}, 64'd1);
    repeat (30) @(negedge clk);
    op(1'b0, 2'd1, 0);
    check("R5 shadow pre-carry", {32'b0, rd_val}, 64'd5);
    tick_en = 1'b0;
    op(1'b0, 2'd0, 0);
    op(1'b0, 2'd1, 0);
    check("R5 high after carry", {32'b0, rd_val}, 64'd6);

    // R7: compare boundaries and level
    op(1'b1, 2'd0, 32'h100); op(1'b1, 2'd1, 0);
    op(1'b1, 2'd2, 32'h101); op(1'b1, 2'd3, 0);
    settle();
    check("R7 count one below compare", {63'b0, irq_req}, 64'd0);
    op(1'b1, 2'd2, 32'h100);
    check("R7 one-cycle latency", {63'b0, irq_req}, 64'd0);
    settle();
    check("R7 equal reaches", {63'b0, irq_req}, 64'd1);
    repeat (10) @(negedge clk);
    check("R7 level holds", {63'b0, irq_req}, 64'd1);

    // R8: gating
    mtie_en = 1'b0; glb_ie = 1'b1; #1;
    check("R8 source disabled", {63'b0, take_irq}, 64'd0);
    mtie_en = 1'b1; glb_ie = 1'b0; #1;
    check("R8 global disabled", {63'b0, take_irq}, 64'd0);
    glb_ie = 1'b1; #1;
    check("R8 all set", {63'b0, take_irq}, 64'd1);

    op(1'b1, 2'd2, 32'h200);
    settle();
    check("R7 cleared by compare move", {63'b0, irq_req}, 64'd0);
    check("R8 no pending", {63'b0, take_irq}, 64'd0);

    // R7: reach by ticking
    op(1'b1, 2'd0, 32'h1FD);
    @(negedge clk); tick_en = 1'b1;
    repeat (2) @(negedge clk);
    tick_en = 1'b0;
    settle(); settle();
    check("R7 tick short of compare", {63'b0, irq_req}, 64'd0);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    settle();
    check("R7 tick onto compare", {63'b0, irq_req}, 64'd1);

    // R7: decided by high halves (unsigned 64-bit)
    op(1'b1, 2'd0, 0); op(1'b1, 2'd1, 1);
    op(1'b1, 2'd2, 32'hFFFF_FFFF); op(1'b1, 2'd3, 0);
    settle();
    check("R7 high half reaches", {63'b0, irq_req}, 64'd1);
    op(1'b1, 2'd3, 2);
    settle();
    check("R7 high compare above", {63'b0, irq_req}, 64'd0);

    // R2: reset again
    op(1'b1, 2'd3, 0);
    settle(); settle();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R2 irq after reset", {63'b0, irq_req}, 64'd0);
    op(1'b0, 2'd1, 0);
    check("R2 shadow after reset", {32'b0, rd_val}, 64'd0);
    op(1'b0, 2'd3, 0);
    check("R2 compare hi after reset", {32'b0, rd_val}, 64'hFFFF_FFFF);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule